// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave end of a two-wire serial memory. It watches the bus lines SCL and SDA, sampling them with the system clock, and picks out START and STOP conditions. It decodes a control byte made of a fixed device code, a strapped device select, a block select and a direction bit. It keeps an address pointer that lasts from one transaction to the next. The slave pulls SDA low through an open-drain enable. It fetches the bytes it sends from a synchronous read port on a 512-byte array, which is arranged as two blocks of 256 bytes.

A master sets the pointer with a write: first the control byte, then a word address. After a repeated START and a control byte for reading, the slave sends bytes. A master can also skip the address write and read from wherever the pointer stands. Each byte the master acknowledges brings the next one. A NACK followed by a STOP ends the burst. Data bytes that follow the word address in a write are acknowledged and then dropped, because programming the storage is not part of this block.

Top module: `i2cmem_slave`

## Requirements
- R1: A control byte is accepted when bits 7:4 equal 1010 and bits 3:2 equal `dev_sel`. Acceptance is shown by SDA held low (`sda_oe`=1) through the ninth SCL pulse.
- R2: If a control byte has a wrong device code or wrong device-select bits, the slave does not drive SDA, makes no memory read and leaves the pointer unchanged until the next START.
- R3: A write that carries an accepted control byte (bit 0 = 0) and then a word address is acknowledged on both bytes. The pointer becomes {bit 1 of the control byte, word address}. Further data bytes in the same write are acknowledged and discarded, and the pointer does not move.
- R4: After an accepted read control byte (bit 0 = 1), the slave sends the byte at the pointer, MSB first. `sda_oe` changes only while SCL is low.
- R5: Each byte the master acknowledges (SDA low on the ninth pulse) is followed by the next consecutive byte. The burst has no length limit.
- R6: A master NACK makes the slave release SDA and drive nothing more. A STOP always releases SDA and returns the slave to idle.
- R7: A read that is not preceded by an address write starts at the pointer left by the previous operation, which is one past the last byte fetched. The block bit of the read control byte selects the block.
- R8: The pointer offset advances modulo 256 inside its block. Offset 0xFF is followed by 0x00 of the same block.
- R9: A START or STOP that arrives partway through a byte aborts the transfer. A word-address byte that was cut short leaves the pointer unchanged.
- R10: Each transmitted byte comes from exactly one `mem_rd_en` pulse, one clock long. The byte is read from `mem_rd_data` one clock after that pulse.
- R11: After reset `sda_oe` is 0, `mem_rd_en` is 0, and the pointer is at offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_sel | input | 2 | Strapped device-select value |
| mem_rd_en | output | 1 | Read strobe to the array |
| mem_addr | output | 9 | Array address {block, offset} |
| mem_rd_data | input | 8 | Array read data, valid one clock after the strobe |

## Verification
Most pointer faults stay hidden until the next read that starts at the current address. A wrong block bit, a lost increment, or a carry into the block bit then shows up as a wrong first byte, within one transaction of the fault. A shift or bit-count fault corrupts the byte in flight or moves the acknowledge slot. The master sees that immediately, as a missing ACK or a wrong data bit on the same byte. A decode fault in the control byte shows at the ninth SCL pulse of that same byte, as an ACK that should not be there or one that is missing.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_HOLD
   } mem_state_t;
endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0] raw;
   logic [1:0] synced;
   logic [1:0] prev;

   assign raw = {scl_i, sda_i};

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cmem_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 2'b11;
      else        prev <= synced;
   end

   assign scl_s     = synced[1];
   assign sda_s     = synced[0];
   assign scl_rise  = synced[1] & ~prev[1];
   assign scl_fall  = ~synced[1] & prev[1];
   assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
   assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
   parameter int OFF_W = 8,
   parameter int BLK_W = 1,
   localparam int ADDR_W = OFF_W + BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_blk,
   input  logic [BLK_W-1:0]  blk_in,
   input  logic              load_off,
   input  logic [OFF_W-1:0]  off_in,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] rd_addr
);
   logic [BLK_W-1:0] blk_q;
   logic [OFF_W-1:0] off_q;
   logic [BLK_W-1:0] blk_eff;

   if (BLK_W < 1) begin : g_bad_blk
      $error("i2cmem_ptr: BLK_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= '0;
         off_q <= '0;
      end else begin
         if (set_blk) blk_q <= blk_in;
         if (load_off)  off_q <= off_in;
         else if (inc)  off_q <= off_q + 1'b1;
      end
   end

   assign blk_eff = set_blk ? blk_in : blk_q;
   assign ptr_q   = {blk_q, off_q};
   assign rd_addr = {blk_eff, off_q};
endmodule

// File: rtl/i2cmem_rdbuf.sv
module i2cmem_rdbuf #(
   parameter int LAT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] rd_data,
   output logic [7:0] data_q
);
   logic valid;

   if (LAT < 1 || LAT > 4) begin : g_bad_lat
      $error("i2cmem_rdbuf: LAT must be 1 to 4");
   end

   if (LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) valid <= 1'b0;
         else        valid <= req;
      end
   end else begin : g_latn
      logic [LAT-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[LAT-2:0], req};
      end
      assign valid = pipe[LAT-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_q <= '0;
      else if (valid) data_q <= rd_data;
   end
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
   import i2cmem_pkg::*;
#(
   parameter int          OFF_W       = 8,
   parameter int          BLK_W       = 1,
   parameter int          DEV_W       = 2,
   parameter int          SYNC_STAGES = 2,
   parameter int          RD_LAT      = 1,
   parameter logic [3:0]  CTRL_CODE   = 4'b1010,
   localparam int         ADDR_W      = OFF_W + BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [DEV_W-1:0]  dev_sel,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rd_data
);
   localparam int BLK_LO = 1;
   localparam int DEV_LO = BLK_LO + BLK_W;

   if (4 + DEV_W + BLK_W + 1 != 8) begin : g_bad_ctrl
      $error("i2cmem_slave: control byte fields must total 8 bits");
   end
   if (OFF_W < 1 || OFF_W > 8) begin : g_bad_off
      $error("i2cmem_slave: OFF_W must be 1 to 8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   mem_state_t state, after_ack;
   logic [2:0] bit_cnt;
   logic       byte_rdy;
   logic [7:0] shreg;
   logic [7:0] txsh;
   logic       macked;
   logic [7:0] txbuf;

   logic             byte_evt;
   logic             code_ok, dev_ok, ctrl_hit, rw_bit;
   logic [BLK_W-1:0] blk_field;
   logic             fetch;
   logic             load_off;
   logic [ADDR_W-1:0] ptr_q;

   assign byte_evt  = byte_rdy & scl_fall;
   assign code_ok   = (shreg[7:4] == CTRL_CODE);
   assign dev_ok    = (shreg[DEV_LO +: DEV_W] == dev_sel);
   assign blk_field = shreg[BLK_LO +: BLK_W];
   assign rw_bit    = shreg[0];
   assign ctrl_hit  = (state == ST_CTRL) & byte_evt & code_ok & dev_ok;
   assign fetch     = (ctrl_hit & rw_bit) |
                      ((state == ST_MACK) & scl_rise & ~sda_s);
   assign load_off  = (state == ST_ADDR) & byte_evt;
   assign mem_rd_en = fetch;

   i2cmem_ptr #(.OFF_W(OFF_W), .BLK_W(BLK_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .set_blk(ctrl_hit), .blk_in(blk_field),
      .load_off(load_off), .off_in(shreg[OFF_W-1:0]),
      .inc(fetch), .ptr_q(ptr_q), .rd_addr(mem_addr)
   );

   i2cmem_rdbuf #(.LAT(RD_LAT)) u_rdbuf (
      .clk(clk), .rst_n(rst_n), .req(fetch),
      .rd_data(mem_rd_data), .data_q(txbuf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         bit_cnt   <= '0;
         byte_rdy  <= 1'b0;
         shreg     <= '0;
         txsh      <= '0;
         macked    <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         state    <= ST_CTRL;
         bit_cnt  <= '0;
         byte_rdy <= 1'b0;
         sda_oe   <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_rdy <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         case (state)
            ST_CTRL, ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == 3'd7) byte_rdy <= 1'b1;
               end else if (byte_evt) begin
                  byte_rdy <= 1'b0;
                  if (state == ST_CTRL) begin
                     if (ctrl_hit) begin
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= rw_bit ? ST_TX : ST_ADDR;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else begin
                     sda_oe    <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  state   <= after_ack;
                  if (after_ack == ST_TX) begin
                     txsh   <= txbuf;
                     sda_oe <= ~txbuf[7];
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_MACK;
                  end else begin
                     sda_oe  <= ~txsh[6];
                     txsh    <= {txsh[6:0], 1'b0};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  macked <= ~sda_s;
               end else if (scl_fall) begin
                  if (macked) begin
                     txsh    <= txbuf;
                     sda_oe  <= ~txbuf[7];
                     bit_cnt <= '0;
                     state   <= ST_TX;
                  end else begin
                     state <= ST_HOLD;
                  end
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk #(
   parameter int ADDR_W = 9,
   parameter int OFF_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_det,
   input logic              stop_det,
   input logic              sda_oe,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] ptr_q
);
   assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (ptr_q[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])) &&
                    (ptr_q[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));

   assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(!scl_s));

   assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && !mem_rd_en));
endmodule

bind i2cmem_slave i2cmem_slave_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .mem_rd_en(mem_rd_en),
   .mem_addr(mem_addr), .ptr_q(ptr_q)
);

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;
   localparam int Q = 10;
   localparam logic [1:0] DEV = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, mem_rd_en;
   logic [8:0] mem_addr;
   logic [7:0] mem_rd_data = '0;
   logic sda_line;

   int n_tests = 0, n_fail = 0;
   int rd_cnt = 0, oe_cnt = 0, viol = 0;
   logic prev_oe = 1'b0;
   logic [8:0] exp_ptr = '0;

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2cmem_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_sel(DEV), .mem_rd_en(mem_rd_en),
      .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
   );

   function automatic logic [7:0] mval(input logic [8:0] a);
      return 8'(a[7:0] * 8'd37) ^ (a[8] ? 8'hC3 : 8'h1E);
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= mval(mem_addr);
         rd_cnt <= rd_cnt + 1;
      end
      if (sda_oe) oe_cnt <= oe_cnt + 1;
      prev_oe <= sda_oe;
      if (sda_oe != prev_oe && scl_m) viol <= viol + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hp(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
      end
      hp();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
      ack = ~sda_line;
      scl_m = 1'b0; hp();
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         hp(); scl_m = 1'b1; hp(); b = {b[6:0], sda_line}; scl_m = 1'b0;
      end
      hp(); sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] ctl(input logic [1:0] dev, input logic blk, input logic rw);
      return {4'b1010, dev, blk, rw};
   endfunction

   // read len bytes from the pointer with block blk, checking each one
   task automatic read_burst(input logic blk, input int len, input string req);
      bit ack;
      logic [7:0] b;
      int rd0;
      logic [8:0] a;
      rd0 = rd_cnt;
      send_byte(ctl(DEV, blk, 1'b1), ack);
      chk(ack, "R1 read ctrl ack", ack, 1);
      a = {blk, exp_ptr[7:0]};
      for (int i = 0; i < len; i++) begin
         recv_byte(i != len - 1, b);
         chk(b == mval(a), req, b, mval(a));
         a = {a[8], 8'(a[7:0] + 1)};
      end
      bus_stop();
      exp_ptr = a;
      chk(rd_cnt - rd0 == len, "R10 fetch count", rd_cnt - rd0, len);
      chk(sda_oe == 1'b0, "R6 released after stop", sda_oe, 0);
   endtask

   task automatic set_ptr(input logic blk, input logic [7:0] off);
      bit ack;
      bus_start();
      send_byte(ctl(DEV, blk, 1'b0), ack);
      chk(ack, "R3 write ctrl ack", ack, 1);
      send_byte(off, ack);
      chk(ack, "R3 word address ack", ack, 1);
      exp_ptr = {blk, off};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] b;
      int oe0, rd0;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0 && mem_rd_en == 1'b0, "R11 reset outputs", sda_oe, 0);
      rst_n = 1'b1;
      hp();

      // R11 R7: current-address read right after reset starts at offset 0
      bus_start();
      read_burst(1'b0, 1, "R11 read at reset pointer");

      // R3 R4 R5: random read, block 1, offset 0x10, 3 bytes
      set_ptr(1'b1, 8'h10);
      bus_start();
      read_burst(1'b1, 3, "R5 sequential data");

      // R7: current read continues from previous pointer
      bus_start();
      read_burst(1'b1, 2, "R7 current address data");

      // R8: wrap inside block 0
      set_ptr(1'b0, 8'hFE);
      bus_start();
      read_burst(1'b0, 4, "R8 wrap data");
      bus_start();
      read_burst(1'b0, 1, "R8 pointer after wrap");

      // R8: wrap inside block 1 keeps block bit
      set_ptr(1'b1, 8'hFF);
      bus_start();
      read_burst(1'b1, 2, "R8 block1 wrap data");

      // R2: wrong device select and wrong code are ignored
      oe0 = oe_cnt; rd0 = rd_cnt;
      bus_start();
      send_byte(ctl(~DEV, 1'b0, 1'b1), ack);
      chk(!ack, "R2 no ack wrong device", ack, 0);
      send_byte(8'h00, ack);
      chk(!ack, "R2 ignores later byte", ack, 0);
      bus_start();
      send_byte({4'b1011, DEV, 1'b0, 1'b0}, ack);
      chk(!ack, "R2 no ack wrong code", ack, 0);
      bus_stop();
      chk(oe_cnt == oe0, "R2 SDA never driven", oe_cnt - oe0, 0);
      chk(rd_cnt == rd0, "R2 no memory read", rd_cnt - rd0, 0);
      bus_start();
      read_burst(1'b1, 1, "R2 pointer unchanged");

      // R3: data bytes after the address are acked and discarded
      set_ptr(1'b0, 8'h40);
      send_byte(8'hAA, ack);
      chk(ack, "R3 data byte ack", ack, 1);
      send_byte(8'h55, ack);
      chk(ack, "R3 second data byte ack", ack, 1);
      bus_stop();
      bus_start();
      read_burst(1'b0, 1, "R3 pointer not moved by data");

      // R9: START inside the address byte aborts
      bus_start();
      send_byte(ctl(DEV, 1'b0, 1'b0), ack);
      send_bits(8'h80, 4);
      bus_start();
      read_burst(1'b0, 1, "R9 start abort keeps pointer");

      // R9: STOP inside the address byte aborts
      bus_start();
      send_byte(ctl(DEV, 1'b0, 1'b0), ack);
      send_bits(8'hC3, 5);
      bus_stop();
      bus_start();
      read_burst(1'b0, 1, "R9 stop abort keeps pointer");

      // R6: after NACK the slave stays off the bus
      bus_start();
      send_byte(ctl(DEV, 1'b0, 1'b1), ack);
      recv_byte(1'b0, b);
      chk(b == mval(exp_ptr), "R6 byte before nack", b, mval(exp_ptr));
      exp_ptr = {exp_ptr[8], 8'(exp_ptr[7:0] + 1)};
      oe0 = oe_cnt; rd0 = rd_cnt;
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R6 no data after nack", b, 8'hFF);
      chk(oe_cnt == oe0 && rd_cnt == rd0, "R6 no drive after nack", oe_cnt - oe0, 0);
      bus_stop();

      // constrained random mix of random and current-address reads
      void'($urandom(32'h1A2B));
      for (int it = 0; it < 20; it++) begin
         logic blk;
         logic [7:0] off;
         int len;
         blk = 1'($urandom);
         off = ($urandom % 3 == 0) ? 8'(8'hFC + ($urandom % 4)) : 8'($urandom);
         len = 1 + int'($urandom % 5);
         if ($urandom % 2) begin
            set_ptr(blk, off);
            bus_start();
         end else begin
            bus_start();
         end
         read_burst(blk, len, "R5 R7 random read data");
      end

      chk(viol == 0, "R4 SDA change while SCL high", viol, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule